// File: doc/BRIEF.md
# Fetch-Run Next-Address Predictor

This block tells the instruction fetch unit where the next run of sequential instructions starts. It works from the start address of the current run and does not wait for instruction-cache data. The fetch address presented in one cycle is registered. In the following cycle, a hash of that address selects one entry of a small table.

Each entry carries a partial tag and a few branch slots. Each slot holds a valid bit, a taken bit, the instruction offset of the branch within the aligned fetch block, and the branch target. The block scans the slots for the earliest branch that is predicted taken and lies at or after the point where fetch entered the block. If one is found, its target is the next fetch address. Otherwise fetch falls through to the next aligned block.

Because the lookup and the selection sit in a single cycle behind one register, the fetch unit can feed the prediction straight back as the next fetch address every cycle. Branch resolution trains the table through an update port. That port carries the branch address, its resolved target and its taken outcome.

Top module: `next_run_predictor`

## Requirements
- R1: A synchronous active-high reset drives pred_valid low and invalidates every entry and slot, so any lookup after reset yields the fall-through address.
- R2: pred_valid in the cycle after a clock edge equals the fetch_valid sampled at that edge. pred_next gives the prediction for the fetch_addr sampled at that edge, so feeding pred_next back as fetch_addr gives one new prediction per cycle.
- R3: The entry index is fetch_addr[10:5] XOR fetch_addr[16:11] and the stored tag is fetch_addr[20:11]. A lookup hits only when the indexed entry is valid and its tag equals the lookup tag.
- R4: On a miss, or when no slot qualifies, pred_next is the fetch address with bits [4:0] cleared plus 32, wrapping modulo 2^32.
- R5: The branch offset of an address is bits [4:2]. A slot qualifies only if it is valid, its taken bit is 1, and its offset is greater than or equal to the fetch address offset.
- R6: When slots qualify, pred_next is the target of the qualifying slot with the smallest offset, whatever the slot position.
- R7: An update that hits an entry with a valid slot of the same offset overwrites that slot's target and taken bit. Writing taken=0 removes the branch from selection.
- R8: An update that hits but finds no slot with its offset writes the lowest-numbered invalid slot. If all four slots are valid, it replaces slot 3. No entry ever holds two valid slots with the same offset.
- R9: An update that misses (entry invalid or tag different) takes over the entry. It writes the new tag, places the branch in slot 0 and invalidates the other slots.
- R10: An update sampled at a clock edge is already visible to the prediction for a fetch address sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | fetch_addr carries a run start to look up |
| fetch_addr | input | 32 | Byte address where the current fetch run starts |
| pred_valid | output | 1 | pred_next is meaningful |
| pred_next | output | 32 | Predicted start address of the next fetch run |
| upd_valid | input | 1 | Write a resolved branch into the table |
| upd_addr | input | 32 | Byte address of the resolved branch |
| upd_target | input | 32 | Resolved branch target |
| upd_taken | input | 1 | Resolved direction, 1 for taken |

## Verification
Directed lookups enter one trained block at offsets 0, 2, 3, 4, 5 and 7. Entering exactly at a branch and entering one past it show whether the eligibility comparison is inclusive. Training the branches out of offset order shows whether selection follows offset or slot position. A not-taken rewrite and a fifth branch into a full entry tell overwrite apart from allocation and eviction. An aliasing address with the same index and a different tag checks the tag compare and the clearing of the other slots.

A chain that feeds pred_next back as the next fetch address exercises the single-cycle recurrence. That run includes a redirect into the middle of a block. A same-edge update-and-fetch case pins down when writes become visible. Seeded random traffic over a small address pool then mixes hits, aliasing, evictions and the wrap at the top of the address space.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

   // Outcome of the update path for one write
   typedef enum logic [1:0] {
      WR_SAME_SLOT  = 2'd0,
      WR_FREE_SLOT  = 2'd1,
      WR_EVICT_SLOT = 2'd2,
      WR_NEW_ENTRY  = 2'd3
   } wr_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/nrp_hash.sv
module nrp_hash #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned BLK_LSB = 5,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned TAG_W   = 10,
   parameter bit          FOLD    = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);

   localparam int unsigned UPPER_LSB = BLK_LSB + IDX_W;

   logic unused_hash_bits;
   assign unused_hash_bits = ^addr;

   generate
      if (FOLD) begin : g_fold
         assign idx = addr[BLK_LSB +: IDX_W] ^ addr[UPPER_LSB +: IDX_W];
      end else begin : g_direct
         assign idx = addr[BLK_LSB +: IDX_W];
      end
   endgenerate

   assign tag = addr[UPPER_LSB +: TAG_W];

endmodule

// File: rtl/nrp_table.sv
module nrp_table
   import nrp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned SLOTS   = 4,
   parameter int unsigned TAG_W   = 10,
   parameter int unsigned OFF_W   = 3,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic                             clk,
   input  logic                             rst,
   // lookup read port (combinational)
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic                             rd_ent_vld,
   output logic [TAG_W-1:0]                 rd_tag,
   output logic [SLOTS-1:0]                 rd_svld,
   output logic [SLOTS-1:0]                 rd_stkn,
   output logic [SLOTS-1:0][OFF_W-1:0]      rd_soff,
   output logic [SLOTS-1:0][ADDR_W-1:0]     rd_stgt,
   // training write port
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [TAG_W-1:0]                 wr_tag,
   input  logic [OFF_W-1:0]                 wr_off,
   input  logic [ADDR_W-1:0]                wr_tgt,
   input  logic                             wr_tkn
);

   logic              ent_vld  [ENTRIES];
   logic [TAG_W-1:0]  ent_tag  [ENTRIES];
   logic [SLOTS-1:0]  slot_vld [ENTRIES];
   logic              slot_tkn [ENTRIES][SLOTS];
   logic [OFF_W-1:0]  slot_off [ENTRIES][SLOTS];
   logic [ADDR_W-1:0] slot_tgt [ENTRIES][SLOTS];

   // ---------------- read port ----------------
   assign rd_ent_vld = ent_vld[rd_idx];
   assign rd_tag     = ent_tag[rd_idx];
   assign rd_svld    = slot_vld[rd_idx];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_rd
         assign rd_stkn[s] = slot_tkn[rd_idx][s];
         assign rd_soff[s] = slot_off[rd_idx][s];
         assign rd_stgt[s] = slot_tgt[rd_idx][s];
      end
   endgenerate

   // ---------------- slot choice for a write ----------------
   logic              w_hit;
   logic [SLOTS-1:0]  w_match;
   logic [SLOTS-1:0]  w_free;
   logic [SLOT_W-1:0] wr_slot;
   wr_kind_e          wr_kind;

   always_comb begin
      w_hit = ent_vld[wr_idx] && (ent_tag[wr_idx] == wr_tag);
      for (int s = 0; s < SLOTS; s++) begin
         w_match[s] = slot_vld[wr_idx][s] && (slot_off[wr_idx][s] == wr_off);
         w_free[s]  = !slot_vld[wr_idx][s];
      end
   end

   always_comb begin
      wr_kind = WR_EVICT_SLOT;
      wr_slot = SLOT_W'(SLOTS - 1);
      if (!w_hit) begin
         wr_kind = WR_NEW_ENTRY;
         wr_slot = '0;
      end else if (|w_match) begin
         wr_kind = WR_SAME_SLOT;
         for (int s = SLOTS - 1; s >= 0; s--)
            if (w_match[s]) wr_slot = SLOT_W'(s);
      end else if (|w_free) begin
         wr_kind = WR_FREE_SLOT;
         for (int s = SLOTS - 1; s >= 0; s--)
            if (w_free[s]) wr_slot = SLOT_W'(s);
      end
   end

   // ---------------- state ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int e = 0; e < ENTRIES; e++) begin
            ent_vld[e]  <= 1'b0;
            slot_vld[e] <= '0;
         end
      end else if (wr_en) begin
         ent_vld[wr_idx] <= 1'b1;
         if (wr_kind == WR_NEW_ENTRY)
            slot_vld[wr_idx] <= SLOTS'(1);
         else
            slot_vld[wr_idx][wr_slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_tag[wr_idx]           <= wr_tag;
         slot_tkn[wr_idx][wr_slot] <= wr_tkn;
         slot_off[wr_idx][wr_slot] <= wr_off;
         slot_tgt[wr_idx][wr_slot] <= wr_tgt;
      end
   end

   // ---------------- checks ----------------
   // R8
   wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (ent_vld[$past(wr_idx)] && slot_vld[$past(wr_idx)][$past(wr_slot)]))
      else $error("written slot not valid after write");

   // R9
   new_entry_single_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !w_hit) |=> ($countones(slot_vld[$past(wr_idx)]) == 1 && slot_vld[$past(wr_idx)][0]))
      else $error("new entry must hold only slot 0");

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_pi
         for (genvar j = i + 1; j < SLOTS; j++) begin : g_pj
            // R8
            no_dup_off_chk: assert property (@(posedge clk) disable iff (rst)
               (rd_svld[i] && rd_svld[j]) |-> (rd_soff[i] != rd_soff[j]))
               else $error("two valid slots share an offset");
         end
      end
   endgenerate

endmodule

// File: rtl/nrp_select.sv
module nrp_select #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned OFF_W  = 3
) (
   input  logic                         hit,
   input  logic [SLOTS-1:0]             svld,
   input  logic [SLOTS-1:0]             stkn,
   input  logic [SLOTS-1:0][OFF_W-1:0]  soff,
   input  logic [SLOTS-1:0][ADDR_W-1:0] stgt,
   input  logic [OFF_W-1:0]             cur_off,
   output logic                         take,
   output logic [OFF_W-1:0]             sel_off,
   output logic [ADDR_W-1:0]            sel_tgt
);

   logic [SLOTS-1:0] elig;

   always_comb begin
      for (int s = 0; s < SLOTS; s++)
         elig[s] = hit && svld[s] && stkn[s] && (soff[s] >= cur_off);
   end

   // earliest offset among eligible slots
   always_comb begin
      take    = 1'b0;
      sel_off = '0;
      sel_tgt = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (elig[s] && (!take || (soff[s] < sel_off))) begin
            take    = 1'b1;
            sel_off = soff[s];
            sel_tgt = stgt[s];
         end
      end
   end

endmodule

// File: rtl/next_run_predictor.sv
module next_run_predictor
   import nrp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned INSN_BYTES  = 4,
   parameter int unsigned BLOCK_INSNS = 8,
   parameter int unsigned SLOTS       = 4,
   parameter int unsigned ENTRIES     = 64,
   parameter int unsigned TAG_W       = 10,
   parameter bit          HASH_FOLD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              pred_valid,
   output logic [ADDR_W-1:0] pred_next,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              upd_taken
);

   localparam int unsigned OFF_LSB = $clog2(INSN_BYTES);
   localparam int unsigned OFF_W   = $clog2(BLOCK_INSNS);
   localparam int unsigned BLK_LSB = OFF_LSB + OFF_W;
   localparam int unsigned IDX_W   = $clog2(ENTRIES);
   localparam int unsigned PAGE_W  = ADDR_W - BLK_LSB;
   localparam int unsigned HI_NEED = BLK_LSB + IDX_W + ((TAG_W > IDX_W) ? TAG_W : IDX_W);

   initial begin
      entries_pow2_chk: assert (is_pow2(ENTRIES)) else $error("ENTRIES must be a power of two");
      slots_pow2_chk:   assert (is_pow2(SLOTS) && SLOTS >= 2) else $error("SLOTS must be a power of two, at least 2");
      block_pow2_chk:   assert (is_pow2(BLOCK_INSNS) && BLOCK_INSNS >= 2) else $error("BLOCK_INSNS must be a power of two");
      insn_pow2_chk:    assert (is_pow2(INSN_BYTES)) else $error("INSN_BYTES must be a power of two");
      slots_fit_chk:    assert (SLOTS <= BLOCK_INSNS) else $error("more slots than instructions per block");
      addr_fit_chk:     assert (HI_NEED <= ADDR_W) else $error("index and tag exceed address width");
   end

   // ---------------- registered run start ----------------
   logic              cur_valid;
   logic [ADDR_W-1:0] cur_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_valid <= 1'b0;
         cur_addr  <= '0;
      end else begin
         cur_valid <= fetch_valid;
         cur_addr  <= fetch_addr;
      end
   end

   // ---------------- hashing ----------------
   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tag, up_tag;

   nrp_hash #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W), .FOLD(HASH_FOLD))
      u_hash_lk (.addr(cur_addr), .idx(lk_idx), .tag(lk_tag));

   nrp_hash #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W), .FOLD(HASH_FOLD))
      u_hash_up (.addr(upd_addr), .idx(up_idx), .tag(up_tag));

   // ---------------- table ----------------
   logic                         rd_ent_vld;
   logic [TAG_W-1:0]             rd_tag;
   logic [SLOTS-1:0]             rd_svld, rd_stkn;
   logic [SLOTS-1:0][OFF_W-1:0]  rd_soff;
   logic [SLOTS-1:0][ADDR_W-1:0] rd_stgt;

   nrp_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS), .TAG_W(TAG_W), .OFF_W(OFF_W))
      u_table (
         .clk        (clk),
         .rst        (rst),
         .rd_idx     (lk_idx),
         .rd_ent_vld (rd_ent_vld),
         .rd_tag     (rd_tag),
         .rd_svld    (rd_svld),
         .rd_stkn    (rd_stkn),
         .rd_soff    (rd_soff),
         .rd_stgt    (rd_stgt),
         .wr_en      (upd_valid),
         .wr_idx     (up_idx),
         .wr_tag     (up_tag),
         .wr_off     (upd_addr[OFF_LSB +: OFF_W]),
         .wr_tgt     (upd_target),
         .wr_tkn     (upd_taken)
      );

   // ---------------- selection ----------------
   logic              lk_hit;
   logic [OFF_W-1:0]  cur_off;
   logic              take;
   logic [OFF_W-1:0]  sel_off;
   logic [ADDR_W-1:0] sel_tgt;
   logic [ADDR_W-1:0] fall_addr;

   assign lk_hit  = rd_ent_vld && (rd_tag == lk_tag);
   assign cur_off = cur_addr[OFF_LSB +: OFF_W];

   nrp_select #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .OFF_W(OFF_W))
      u_select (
         .hit     (lk_hit),
         .svld    (rd_svld),
         .stkn    (rd_stkn),
         .soff    (rd_soff),
         .stgt    (rd_stgt),
         .cur_off (cur_off),
         .take    (take),
         .sel_off (sel_off),
         .sel_tgt (sel_tgt)
      );

   assign fall_addr  = {cur_addr[ADDR_W-1:BLK_LSB] + PAGE_W'(1), {BLK_LSB{1'b0}}};
   assign pred_next  = take ? sel_tgt : fall_addr;
   assign pred_valid = cur_valid;

   // ---------------- checks ----------------
   // R2
   valid_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pred_valid == $past(fetch_valid)))
      else $error("pred_valid does not follow fetch_valid");

   // R4
   miss_falls_through_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd_ent_vld && rd_tag == lk_tag) |-> !take)
      else $error("redirect chosen on a tag miss");

   // R5
   sel_not_behind_chk: assert property (@(posedge clk) disable iff (rst)
      take |-> (sel_off >= cur_off))
      else $error("selected branch lies before fetch entry point");

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_min
         // R6
         earliest_taken_chk: assert property (@(posedge clk) disable iff (rst)
            (lk_hit && rd_svld[s] && rd_stkn[s] && (rd_soff[s] >= cur_off))
               |-> (take && (sel_off <= rd_soff[s])))
            else $error("an earlier qualifying branch was skipped");
      end
   endgenerate

endmodule

// File: tb/next_run_predictor_test.sv
module next_run_predictor_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        fetch_valid;
   logic [31:0] fetch_addr;
   logic        pred_valid;
   logic [31:0] pred_next;
   logic        upd_valid;
   logic [31:0] upd_addr;
   logic [31:0] upd_target;
   logic        upd_taken;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   next_run_predictor uut (
      .clk         (clk),
      .rst         (rst),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .pred_valid  (pred_valid),
      .pred_next   (pred_next),
      .upd_valid   (upd_valid),
      .upd_addr    (upd_addr),
      .upd_target  (upd_target),
      .upd_taken   (upd_taken)
   );

   // ---------------- reference model from the requirements ----------------
   bit          m_ev  [64];
   bit   [9:0]  m_tag [64];
   bit          m_sv  [64][4];
   bit          m_st  [64][4];
   bit   [2:0]  m_so  [64][4];
   bit   [31:0] m_sg  [64][4];

   function automatic [5:0] h_idx(input logic [31:0] a);
      return a[10:5] ^ a[16:11];
   endfunction

   function automatic [9:0] h_tag(input logic [31:0] a);
      return a[20:11];
   endfunction

   function automatic [31:0] fall_of(input logic [31:0] a);
      return {a[31:5] + 27'd1, 5'd0};
   endfunction

   task automatic m_reset();
      for (int e = 0; e < 64; e++) begin
         m_ev[e] = 0;
         for (int s = 0; s < 4; s++) m_sv[e][s] = 0;
      end
   endtask

   task automatic m_update(input logic [31:0] a, input logic [31:0] t, input bit tk);
      int   ix  = int'(h_idx(a));
      int   pos = -1;
      bit [2:0] off = a[4:2];
      if (m_ev[ix] && m_tag[ix] == h_tag(a)) begin
         for (int s = 3; s >= 0; s--) if (m_sv[ix][s] && m_so[ix][s] == off) pos = s;
         if (pos < 0) for (int s = 3; s >= 0; s--) if (!m_sv[ix][s]) pos = s;
         if (pos < 0) pos = 3;
      end else begin
         m_ev[ix]  = 1;
         m_tag[ix] = h_tag(a);
         for (int s = 0; s < 4; s++) m_sv[ix][s] = 0;
         pos = 0;
      end
      m_sv[ix][pos] = 1;
      m_st[ix][pos] = tk;
      m_so[ix][pos] = off;
      m_sg[ix][pos] = t;
   endtask

   function automatic [31:0] m_predict(input logic [31:0] a);
      int   ix   = int'(h_idx(a));
      int   best = -1;
      if (m_ev[ix] && m_tag[ix] == h_tag(a)) begin
         for (int s = 0; s < 4; s++)
            if (m_sv[ix][s] && m_st[ix][s] && m_so[ix][s] >= a[4:2])
               if (best < 0 || m_so[ix][s] < m_so[ix][best]) best = s;
      end
      return (best < 0) ? fall_of(a) : m_sg[ix][best];
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, edge, check at next negedge
   task automatic cyc(input bit fv, input logic [31:0] fa,
                      input bit uv, input logic [31:0] ua, input logic [31:0] ut, input bit utk,
                      input string req);
      fetch_valid = fv;
      fetch_addr  = fa;
      upd_valid   = uv;
      upd_addr    = ua;
      upd_target  = ut;
      upd_taken   = utk;
      @(posedge clk);
      if (uv) m_update(ua, ut, utk);
      @(negedge clk);
      check({req, " valid (R2)"}, {31'd0, pred_valid}, {31'd0, fv});
      if (fv) check(req, pred_next, m_predict(fa));
   endtask

   task automatic look(input logic [31:0] fa, input string req);
      cyc(1'b1, fa, 1'b0, 32'd0, 32'd0, 1'b0, req);
   endtask

   task automatic train(input logic [31:0] ua, input logic [31:0] ut, input bit tk, input string req);
      cyc(1'b0, 32'd0, 1'b1, ua, ut, tk, req);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired, run hung");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   logic [31:0] pool [8];

   initial begin
      void'($urandom(32'd20240611));
      pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1820;
      pool[2] = 32'h0000_4000; pool[3] = 32'h0000_2000;
      pool[4] = 32'h0000_3000; pool[5] = 32'h0000_0000;
      pool[6] = 32'hFFFF_FFE0; pool[7] = 32'h0000_7FE0;

      m_reset();
      rst = 1'b1; fetch_valid = 1'b1; fetch_addr = 32'h1000;
      upd_valid = 1'b1; upd_addr = 32'h1000; upd_target = 32'h1; upd_taken = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: pred_valid low during reset
      check("R1 pred_valid in reset", {31'd0, pred_valid}, 32'd0);
      rst = 1'b0;

      // R1 / R4: empty table falls through, including a mid-block entry
      look(32'h0000_1234, "R1 empty lookup");
      check("R4 explicit fall-through", pred_next, 32'h0000_1240);

      // R9: first training of a block
      train(32'h0000_100C, 32'h0000_8000, 1'b1, "R9 install");
      look(32'h0000_1000, "R6 single taken");
      check("R6 explicit target", pred_next, 32'h0000_8000);
      look(32'h0000_1014, "R5 entry after branch");
      check("R5 skipped earlier branch", pred_next, 32'h0000_1020);
      look(32'h0000_100C, "R5 entry at branch");
      check("R5 inclusive offset", pred_next, 32'h0000_8000);

      // R8: free-slot allocation out of offset order
      train(32'h0000_1018, 32'h0000_9000, 1'b1, "R8 alloc off6");
      train(32'h0000_1004, 32'h0000_A000, 1'b1, "R8 alloc off1");
      look(32'h0000_1000, "R6 earliest of three");
      check("R6 earliest offset wins", pred_next, 32'h0000_A000);
      look(32'h0000_1008, "R6 entry off2");
      look(32'h0000_1010, "R6 entry off4");
      check("R6 entry off4 target", pred_next, 32'h0000_9000);

      // R7: overwrite direction and target
      train(32'h0000_1004, 32'h0000_A000, 1'b0, "R7 not taken");
      look(32'h0000_1000, "R7 not-taken skipped");
      check("R7 not-taken skipped explicit", pred_next, 32'h0000_8000);
      train(32'h0000_1004, 32'h0000_B000, 1'b1, "R7 retarget");
      look(32'h0000_1000, "R7 new target");
      check("R7 new target explicit", pred_next, 32'h0000_B000);

      // R8: fill the entry, then evict slot 3
      train(32'h0000_101C, 32'h0000_C000, 1'b1, "R8 fourth slot");
      look(32'h0000_101C, "R8 off7 present");
      check("R8 off7 present explicit", pred_next, 32'h0000_C000);
      train(32'h0000_1000, 32'h0000_D000, 1'b1, "R8 evict");
      look(32'h0000_101C, "R8 off7 evicted");
      check("R8 evicted slot gone", pred_next, 32'h0000_1020);
      look(32'h0000_1000, "R8 replacement used");
      check("R8 replacement explicit", pred_next, 32'h0000_D000);

      // R3 / R9: alias on index 2 with a different tag
      train(32'h0000_1824, 32'h0000_E000, 1'b1, "R9 alias takeover");
      look(32'h0000_1000, "R3 tag miss");
      check("R3 old block now misses", pred_next, 32'h0000_1020);
      look(32'h0000_1820, "R3 alias hit");
      check("R3 alias target", pred_next, 32'h0000_E000);
      look(32'h0000_1830, "R9 other slots cleared");
      check("R9 cleared slots", pred_next, 32'h0000_1840);

      // R10: write and lookup sampled on the same edge
      cyc(1'b1, 32'h0000_4000, 1'b1, 32'h0000_4008, 32'h0000_7700, 1'b1, "R10 same edge");
      check("R10 same-edge visibility", pred_next, 32'h0000_7700);

      // R2: closed recurrence, prediction fed back as fetch address
      train(32'h0000_2000, 32'h0000_2008, 1'b1, "R2 chain a");
      train(32'h0000_2004, 32'h0000_5000, 1'b1, "R2 chain b");
      train(32'h0000_2014, 32'h0000_3000, 1'b1, "R2 chain c");
      look(32'h0000_2000, "R2 chain start");
      check("R2 hop 1", pred_next, 32'h0000_2008);
      look(pred_next, "R2 chain hop");
      check("R2 hop 2 skips off1", pred_next, 32'h0000_3000);
      look(pred_next, "R2 chain hop");
      check("R2 hop 3 falls through", pred_next, 32'h0000_3020);

      // R4: wrap at the top of the address space
      look(32'hFFFF_FFF4, "R4 wrap");
      check("R4 wrap explicit", pred_next, 32'h0000_0000);

      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] fa = pool[$urandom_range(7)] | ({29'd0, 3'($urandom_range(7))} << 2);
         logic [31:0] ua = pool[$urandom_range(7)] | ({29'd0, 3'($urandom_range(7))} << 2);
         logic [31:0] ut = $urandom() & 32'hFFFF_FFFC;
         cyc($urandom_range(3) != 0, fa, $urandom_range(2) == 0, ua, ut,
             $urandom_range(3) != 0, "R6 random");
      end

      // R1: reset mid-run clears everything
      rst = 1'b1;
      m_reset();
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      look(32'h0000_1820, "R1 after second reset");
      check("R1 cleared table", pred_next, 32'h0000_1840);

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

endmodule